// File: doc/BRIEF.md
# Active Priority Preemption Tracker

This block keeps, for one processor, the record of which preemption levels are currently being serviced. It also derives the running priority from that record. When an interrupt is acknowledged, the block receives its 8-bit priority and its group. It masks the priority down to a group priority with the applicable binary point and marks the matching preemption level in that group's active bitmap. The running priority then takes the group priority.

When an end-of-interrupt arrives for a group, the most urgent marked level of that group is retired. The running priority is then rebuilt from the most urgent level still marked in either group. If no level is marked anywhere, the running priority returns to the idle value 0x100.

The block also holds the two binary point registers, main and aliased, each with a minimum-value clamp. Choosing which interrupt to acknowledge and decoding bus accesses belong to neighbouring logic. All outputs are registered and change one clock after the input that causes them.

Top module: `active_prio_tracker`

## Requirements
- R1: After reset the running priority is 0x100, both active bitmaps are zero, the main binary point equals MIN_BPR, the aliased binary point equals MIN_ABPR, and the collision flag is 0.
- R2: The group priority is the acknowledged priority ANDed with 8'hFF shifted left by (binary point + 1). A binary point of 0 keeps bits [7:1], and a binary point of 7 keeps no bits.
- R3: A group-1 acknowledge (ack_grp1=1) uses the aliased binary point when cbpr=0 and the main binary point when cbpr=1. A group-0 acknowledge always uses the main binary point.
- R4: On an accepted acknowledge, bit (group priority >> (MIN_BPR+1)) is set in the bitmap of the acknowledged group. Bit n of act_grp0/act_grp1 is level n. One cycle later, run_prio equals the group priority.
- R5: An accepted end-of-interrupt clears only the lowest set bit of the bitmap named by eoi_grp1 (0 selects group 0, 1 selects group 1). It leaves every other bit of both bitmaps unchanged.
- R6: After an accepted end-of-interrupt, run_prio is (index of the lowest set bit of the OR of both bitmaps) shifted left by (MIN_BPR+1). It is 0x100 when both bitmaps are zero.
- R7: An end-of-interrupt is ignored, leaving the bitmaps and run_prio unchanged, when eoi_id is at or above NUM_IDS (including 1023) or when run_prio is 0x100.
- R8: A binary point write keeps bp_wdata[2:0] and raises it to the register's minimum: MIN_BPR for the main register (bpr_wr) and MIN_ABPR for the aliased register (abpr_wr).
- R9: An acknowledge and an end-of-interrupt in the same cycle set collide to 1 for the following cycle, and neither is processed. In every other cycle collide is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_prio | input | 8 | Priority of the acknowledged interrupt |
| ack_grp1 | input | 1 | Acknowledged interrupt is group 1 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | ID_W | Interrupt ID given with the end-of-interrupt |
| eoi_grp1 | input | 1 | End-of-interrupt targets the group-1 bitmap |
| cbpr | input | 1 | Common binary point: group 1 uses the main binary point |
| bpr_wr | input | 1 | Write strobe for the main binary point |
| abpr_wr | input | 1 | Write strobe for the aliased binary point |
| bp_wdata | input | 8 | Binary point write data |
| run_prio | output | 9 | Running priority, 0x100 when idle |
| bpr | output | 3 | Main binary point |
| abpr | output | 3 | Aliased binary point |
| act_grp0 | output | NLEV | Group-0 active level bitmap |
| act_grp1 | output | NLEV | Group-1 active level bitmap |
| collide | output | 1 | Acknowledge and end-of-interrupt collided in the previous cycle |

## Verification
The assertions check, on every cycle, several structural properties. The binary points never fall below their minimums, and the running priority is always aligned to a preemption level. Idle running priority coincides exactly with empty bitmaps. A retirement removes at most one marked level. Collisions and out-of-range IDs leave the state frozen.

Only the bench scenarios can show the actual values. These are the group priority each binary point produces, and the choice between aliased and common binary point. They also cover which level a retirement removes when several are marked across both groups, and the running priority rebuilt afterwards.

// File: rtl/apt_pkg.sv
package apt_pkg;
    localparam int PRIO_W = 8;
    localparam int RUN_W  = PRIO_W + 1;
    localparam logic [RUN_W-1:0] RUN_IDLE = 9'h100;

    // keep the priority bits above the binary point
    function automatic logic [PRIO_W-1:0] group_prio(input logic [PRIO_W-1:0] prio,
                                                     input logic [2:0] bp);
        logic [PRIO_W-1:0] keep;
        keep = 8'hFF << (4'(bp) + 4'd1);
        return prio & keep;
    endfunction
endpackage

// File: rtl/apt_binpoint.sv
module apt_binpoint #(
    parameter int MIN_BPR  = 0,
    parameter int MIN_ABPR = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bpr_wr,
    input  logic       abpr_wr,
    input  logic [7:0] wdata,
    output logic [2:0] bpr_q,
    output logic [2:0] abpr_q
);
    localparam logic [2:0] FLOOR_M = 3'(MIN_BPR);
    localparam logic [2:0] FLOOR_A = 3'(MIN_ABPR);

    typedef struct packed {
        logic [2:0] bpr;
        logic [2:0] abpr;
    } bp_t;

    bp_t s_d, s_q;

    function automatic logic [2:0] clamp(input logic [7:0] v, input logic [2:0] floor_v);
        return (v[2:0] < floor_v) ? floor_v : v[2:0];
    endfunction

    always_comb begin
        s_d = s_q;
        if (bpr_wr)  s_d.bpr  = clamp(wdata, FLOOR_M);
        if (abpr_wr) s_d.abpr = clamp(wdata, FLOOR_A);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.bpr  <= FLOOR_M;
            s_q.abpr <= FLOOR_A;
        end else begin
            s_q <= s_d;
        end
    end

    assign bpr_q  = s_q.bpr;
    assign abpr_q = s_q.abpr;

    assert_bpr_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bpr_q >= FLOOR_M) && (abpr_q >= FLOOR_A));

    assert_bpr_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bpr_wr && wdata[2:0] >= FLOOR_M) |=> (bpr_q == $past(wdata[2:0])));
endmodule

// File: rtl/apt_lowest.sv
module apt_lowest #(
    parameter int W  = 128,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/apt_bitmap.sv
module apt_bitmap #(
    parameter int NLEV = 128,
    localparam int LW  = $clog2(NLEV)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [LW-1:0]   set_lvl,
    input  logic            clr_en,
    output logic [NLEV-1:0] bits_d,
    output logic [NLEV-1:0] bits_q
);
    always_comb begin
        bits_d = bits_q;
        if (set_en)
            bits_d = bits_q | (NLEV'(1) << set_lvl);
        else if (clr_en)
            bits_d = bits_q & (bits_q - NLEV'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assert_single_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en && bits_q != '0) |=>
            ($countones(bits_q) + 1 == $countones($past(bits_q))));

    assert_level_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> bits_q[$past(set_lvl)]);
endmodule

// File: rtl/active_prio_tracker.sv
module active_prio_tracker
    import apt_pkg::*;
#(
    parameter int MIN_BPR  = 0,
    parameter int MIN_ABPR = MIN_BPR + 1,
    parameter int NUM_IDS  = 96,
    parameter int ID_W     = 10,
    localparam int SH      = MIN_BPR + 1,
    localparam int NLEV    = 128 >> MIN_BPR,
    localparam int LW      = $clog2(NLEV)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ack_valid,
    input  logic [7:0]      ack_prio,
    input  logic            ack_grp1,
    input  logic            eoi_valid,
    input  logic [ID_W-1:0] eoi_id,
    input  logic            eoi_grp1,
    input  logic            cbpr,
    input  logic            bpr_wr,
    input  logic            abpr_wr,
    input  logic [7:0]      bp_wdata,
    output logic [8:0]      run_prio,
    output logic [2:0]      bpr,
    output logic [2:0]      abpr,
    output logic [NLEV-1:0] act_grp0,
    output logic [NLEV-1:0] act_grp1,
    output logic            collide
);
    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             collide;
    } st_t;

    st_t s_d, s_q;

    logic            both, ack_do, eoi_ok;
    logic [2:0]      bp_sel;
    logic [7:0]      gprio;
    logic [LW-1:0]   lvl;
    logic [NLEV-1:0] nxt [2];
    logic [NLEV-1:0] cur [2];
    logic            lo_found;
    logic [LW-1:0]   lo_idx;

    apt_binpoint #(.MIN_BPR(MIN_BPR), .MIN_ABPR(MIN_ABPR)) u_bp (
        .clk(clk), .rst_n(rst_n), .bpr_wr(bpr_wr), .abpr_wr(abpr_wr),
        .wdata(bp_wdata), .bpr_q(bpr), .abpr_q(abpr)
    );

    assign both   = ack_valid & eoi_valid;
    assign ack_do = ack_valid & ~eoi_valid;
    assign eoi_ok = eoi_valid & ~ack_valid & (int'(eoi_id) < NUM_IDS)
                  & (s_q.run != RUN_IDLE);

    // group 1 takes the aliased binary point unless the common one is selected
    assign bp_sel = (ack_grp1 && !cbpr) ? abpr : bpr;
    assign gprio  = group_prio(ack_prio, bp_sel);
    assign lvl    = LW'(gprio >> SH);

    for (genvar g = 0; g < 2; g++) begin : g_grp
        apt_bitmap #(.NLEV(NLEV)) u_map (
            .clk(clk), .rst_n(rst_n),
            .set_en(ack_do && (ack_grp1 == 1'(g))),
            .set_lvl(lvl),
            .clr_en(eoi_ok && (eoi_grp1 == 1'(g))),
            .bits_d(nxt[g]),
            .bits_q(cur[g])
        );
    end

    apt_lowest #(.W(NLEV)) u_low (
        .vec(nxt[0] | nxt[1]), .found(lo_found), .idx(lo_idx)
    );

    always_comb begin
        s_d         = s_q;
        s_d.collide = both;
        if (ack_do)
            s_d.run = {1'b0, gprio};
        else if (eoi_ok)
            s_d.run = lo_found ? (RUN_W'(lo_idx) << SH) : RUN_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.run     <= RUN_IDLE;
            s_q.collide <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_prio = s_q.run;
    assign collide  = s_q.collide;
    assign act_grp0 = cur[0];
    assign act_grp1 = cur[1];

    assert_run_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_prio[SH-1:0] == '0);

    assert_idle_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_prio == RUN_IDLE) == ((act_grp0 | act_grp1) == '0));

    assert_collide_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && eoi_valid) |=>
            (collide && $stable(act_grp0) && $stable(act_grp1) && $stable(run_prio)));

    assert_bad_id_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !ack_valid && int'(eoi_id) >= NUM_IDS) |=>
            ($stable(act_grp0) && $stable(act_grp1) && $stable(run_prio)));
endmodule

// File: tb/active_prio_tracker_test.sv
module active_prio_tracker_test;
    localparam int NL = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ack_valid = 0, ack_grp1 = 0, eoi_valid = 0, eoi_grp1 = 0;
    logic [7:0]    ack_prio = 0, bp_wdata = 0;
    logic [9:0]    eoi_id = 0;
    logic          cbpr = 0, bpr_wr = 0, abpr_wr = 0;
    logic [8:0]    run_prio;
    logic [2:0]    bpr, abpr;
    logic [NL-1:0] act_grp0, act_grp1;
    logic          collide;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    active_prio_tracker uut (
        .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_prio(ack_prio),
        .ack_grp1(ack_grp1), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
        .eoi_grp1(eoi_grp1), .cbpr(cbpr), .bpr_wr(bpr_wr), .abpr_wr(abpr_wr),
        .bp_wdata(bp_wdata), .run_prio(run_prio), .bpr(bpr), .abpr(abpr),
        .act_grp0(act_grp0), .act_grp1(act_grp1), .collide(collide)
    );

    function automatic logic [NL-1:0] lv(input int n);
        return NL'(1) << n;
    endfunction

    task automatic check(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag, input logic [8:0] er,
                               input logic [NL-1:0] e0, input logic [NL-1:0] e1);
        check({tag, " run"},  NL'(run_prio), NL'(er));
        check({tag, " grp0"}, act_grp0, e0);
        check({tag, " grp1"}, act_grp1, e1);
    endtask

    task automatic do_ack(input logic [7:0] p, input logic g);
        @(negedge clk); ack_valid = 1; ack_prio = p; ack_grp1 = g;
        @(negedge clk); ack_valid = 0;
    endtask

    task automatic do_eoi(input logic [9:0] id, input logic g);
        @(negedge clk); eoi_valid = 1; eoi_id = id; eoi_grp1 = g;
        @(negedge clk); eoi_valid = 0;
    endtask

    task automatic wr_bp(input logic main, input logic [7:0] v);
        @(negedge clk); bpr_wr = main; abpr_wr = !main; bp_wdata = v;
        @(negedge clk); bpr_wr = 0; abpr_wr = 0;
    endtask

    task automatic t_reset;
        check_state("R1 reset", 9'h100, '0, '0);
        check("R1 bpr", NL'(bpr), NL'(0));
        check("R1 abpr", NL'(abpr), NL'(1));
        check("R1 collide", NL'(collide), NL'(0));
    endtask

    task automatic t_binpoint;
        wr_bp(1, 8'hFD); check("R8 bpr low bits", NL'(bpr), NL'(5));
        wr_bp(0, 8'h08); check("R8 abpr clamp", NL'(abpr), NL'(1));
        wr_bp(0, 8'h0E); check("R8 abpr write", NL'(abpr), NL'(6));
        wr_bp(1, 8'h00); check("R8 bpr zero", NL'(bpr), NL'(0));
        wr_bp(0, 8'h01); check("R8 abpr restore", NL'(abpr), NL'(1));
    endtask

    task automatic t_ack_and_retire;
        do_ack(8'h47, 0);
        check_state("R2 R4 ack grp0", 9'h046, lv(35), '0);
        do_ack(8'h23, 1);
        check_state("R3 alias grp1", 9'h020, lv(35), lv(16));
        do_eoi(10'd5, 1);
        check_state("R6 retire grp1", 9'h046, lv(35), '0);
        do_eoi(10'd96, 0);
        check_state("R7 id at limit", 9'h046, lv(35), '0);
        do_eoi(10'd1023, 0);
        check_state("R7 spurious id", 9'h046, lv(35), '0);
        do_eoi(10'd7, 0);
        check_state("R6 retire to idle", 9'h100, '0, '0);
        do_eoi(10'd7, 0);
        check_state("R7 idle eoi", 9'h100, '0, '0);
    endtask

    task automatic t_cbpr;
        cbpr = 1;
        do_ack(8'h23, 1);
        check_state("R3 common bp", 9'h022, '0, lv(17));
        cbpr = 0;
        do_eoi(10'd2, 1);
        check_state("R3 cleanup", 9'h100, '0, '0);
    endtask

    task automatic t_lowest;
        do_ack(8'h50, 0);
        do_ack(8'h14, 0);
        do_ack(8'h09, 1);
        check_state("R4 nested", 9'h008, lv(40) | lv(10), lv(4));
        do_eoi(10'd1, 0);
        check_state("R5 lowest only", 9'h008, lv(40), lv(4));
        do_eoi(10'd1, 1);
        check_state("R6 across groups", 9'h050, lv(40), '0);
        do_eoi(10'd1, 0);
        check_state("R6 empty", 9'h100, '0, '0);
    endtask

    task automatic t_collide;
        @(negedge clk);
        ack_valid = 1; ack_prio = 8'h30; ack_grp1 = 0;
        eoi_valid = 1; eoi_id = 10'd3; eoi_grp1 = 0;
        @(negedge clk); ack_valid = 0; eoi_valid = 0;
        check("R9 flag", NL'(collide), NL'(1));
        check_state("R9 idle hold", 9'h100, '0, '0);
        @(negedge clk);
        check("R9 flag drops", NL'(collide), NL'(0));
        do_ack(8'h30, 0);
        @(negedge clk);
        ack_valid = 1; ack_prio = 8'h10; ack_grp1 = 1;
        eoi_valid = 1; eoi_id = 10'd3; eoi_grp1 = 0;
        @(negedge clk); ack_valid = 0; eoi_valid = 0;
        check_state("R9 active hold", 9'h030, lv(24), '0);
        do_eoi(10'd3, 0);
        check_state("R9 cleanup", 9'h100, '0, '0);
    endtask

    task automatic t_bpr7;
        wr_bp(1, 8'h07);
        do_ack(8'hFF, 0);
        check_state("R2 bp seven", 9'h000, lv(0), '0);
        do_eoi(10'd9, 0);
        check_state("R2 bp seven retire", 9'h100, '0, '0);
        wr_bp(1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_binpoint();
        t_ack_and_retire();
        t_cbpr();
        t_lowest();
        t_collide();
        t_bpr7();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule